// File: doc/BRIEF.md
# Snooping MSI Line Coherence Controller

This block keeps a small direct-mapped set of writeback cache lines coherent on a shared snooping bus. Each line holds a tag and one of three states: Invalid, Shared or Modified. The processor side issues reads and writes. The bus side delivers transactions observed from other caches. The controller decides when a processor access can finish locally and when it must first own a bus transaction. When another cache's request touches a dirty line, the controller asserts a flush so that this cache supplies the data.

The low `IDX_W` bits of an address select a line and the remaining bits form the tag. A processor request is held, with its address and direction stable, until `cpu_ready_o` is high. A transaction is requested with `bus_req_o` and takes effect in the cycle `bus_gnt_i` is high. A miss that lands on a line holding a different dirty tag first writes that victim back, and then fetches the new line. A snoop is applied in the cycle it arrives, before any processor action on the same cycle, and `flush_o` answers it in that same cycle.

Top module: `msi_line_ctrl`

## Requirements
- R1: A processor read whose line is Shared or Modified with a matching tag completes in the same cycle (`cpu_ready_o`=1) without raising `bus_req_o`.
- R2: A processor read that misses requests a bus read (`bus_cmd_o`=2'b01) at the request address. On grant it completes and the line becomes Shared (`cpu_state_o`=2'b01).
- R3: A processor write to a Shared line, or a write that misses, requests read-to-own (`bus_cmd_o`=2'b10) at the request address. On grant it completes and the line becomes Modified (`cpu_state_o`=2'b10).
- R4: A processor write to a Modified line with a matching tag completes in the same cycle without a bus request, and the line stays Modified.
- R5: A snooped bus read (`snp_cmd_i`=2'b01) that hits a Modified line raises `flush_o` in the same cycle, and the line becomes Shared.
- R6: A snooped read-to-own (`snp_cmd_i`=2'b10) that hits a Modified line raises `flush_o` in the same cycle, and the line becomes Invalid.
- R7: A snoop that hits a Shared line never raises `flush_o`. A bus read leaves the line Shared, and a read-to-own makes it Invalid.
- R8: A miss whose line holds a Modified copy of another tag first requests a writeback (`bus_cmd_o`=2'b11) at the victim address {old tag, index}, without completing the processor request. On that grant the victim becomes Invalid, and the fill follows as in R2 or R3.
- R9: While a required transaction is not granted, `cpu_ready_o` stays 0 and `bus_req_o` stays 1 with its command, and the line state is unchanged.
- R10: A snoop in the same cycle as a processor request is applied first. A read to a Shared line that is hit by a snooped read-to-own in that cycle does not complete locally and issues a bus read instead.
- R11: A snoop whose tag differs, that hits an Invalid line, or that carries the writeback code 2'b11 raises no flush and changes no state.
- R12: After reset every line is Invalid (`cpu_state_o`=2'b00), and `bus_req_o`, `flush_o` and `cpu_ready_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor request valid, held until ready |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | ADDR_W | Processor line address |
| cpu_ready_o | output | 1 | Processor request completes this cycle |
| cpu_state_o | output | 2 | Registered state of the line addressed by cpu_addr_i (Invalid on tag mismatch) |
| bus_req_o | output | 1 | Bus transaction wanted |
| bus_cmd_o | output | 2 | 01 read, 10 read-to-own, 11 writeback, 00 none |
| bus_addr_o | output | ADDR_W | Transaction line address |
| bus_gnt_i | input | 1 | Bus grant for the current request |
| snp_valid_i | input | 1 | Snooped transaction valid |
| snp_cmd_i | input | 2 | Snooped command, same encoding as bus_cmd_o |
| snp_addr_i | input | ADDR_W | Snooped line address |
| flush_o | output | 1 | Supply dirty data for the current snoop |

## Verification
The bench builds the controller with an 8-bit address and two index bits, so there are four lines and a 6-bit tag. Its random addresses use only two tag values. With that few lines and tags, a miss often lands on a dirty line of the other tag, which exercises the writeback-then-fill path of R8. The same setup makes a snoop often hit the very line a stalled processor request is waiting on, which exercises the ordering of R10.

// File: rtl/msi_pkg.sv
package msi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'b00,
    ST_S = 2'b01,
    ST_M = 2'b10
  } line_st_e;

  typedef enum logic [1:0] {
    BC_NONE = 2'b00,
    BC_RD   = 2'b01,
    BC_RDX  = 2'b10,
    BC_WB   = 2'b11
  } bus_cmd_e;
endpackage

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  localparam int LINES = 1 << IDX_W,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic [LINES-1:0][1:0]       st_i,
  input  logic [LINES-1:0][TAG_W-1:0] tag_i,
  input  logic                        snp_valid_i,
  input  logic [1:0]                  snp_cmd_i,
  input  logic [ADDR_W-1:0]           snp_addr_i,
  output logic [LINES-1:0][1:0]       st_o,
  output logic                        flush_o
);
  logic [IDX_W-1:0] snp_idx;
  logic [TAG_W-1:0] snp_tag;
  logic             snp_act;
  logic [LINES-1:0] fl;

  assign snp_idx = snp_addr_i[IDX_W-1:0];
  assign snp_tag = snp_addr_i[ADDR_W-1:IDX_W];
  // writebacks from other caches need no response
  assign snp_act = snp_valid_i && (snp_cmd_i == BC_RD || snp_cmd_i == BC_RDX);

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic hit;
    assign hit = snp_act && (snp_idx == IDX_W'(i)) && (tag_i[i] == snp_tag)
                 && (st_i[i] != ST_I);
    always_comb begin
      st_o[i] = st_i[i];
      fl[i]   = 1'b0;
      if (hit) begin
        fl[i]   = (st_i[i] == ST_M);
        st_o[i] = (snp_cmd_i == BC_RDX) ? ST_I : ST_S;
      end
    end
  end

  assign flush_o = |fl;
endmodule

// File: rtl/msi_cpu_unit.sv
module msi_cpu_unit
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [1:0]        cur_st_i,   // state after this cycle's snoop
  input  logic [TAG_W-1:0]  cur_tag_i,
  input  logic              bus_gnt_i,
  output logic              bus_req_o,
  output logic [1:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              ready_o,
  output logic              upd_o,
  output logic [1:0]        upd_st_o,
  output logic [TAG_W-1:0]  upd_tag_o
);
  logic [TAG_W-1:0] req_tag;
  logic [IDX_W-1:0] req_idx;
  logic             hit;

  assign req_tag = cpu_addr_i[ADDR_W-1:IDX_W];
  assign req_idx = cpu_addr_i[IDX_W-1:0];
  assign hit     = (cur_st_i != ST_I) && (cur_tag_i == req_tag);

  always_comb begin
    bus_req_o  = 1'b0;
    bus_cmd_o  = BC_NONE;
    bus_addr_o = '0;
    ready_o    = 1'b0;
    upd_o      = 1'b0;
    upd_st_o   = ST_I;
    upd_tag_o  = cur_tag_i;
    if (cpu_req_i) begin
      if (hit && (!cpu_we_i || cur_st_i == ST_M)) begin
        ready_o = 1'b1;
      end else if (hit) begin
        // upgrade Shared -> Modified
        bus_req_o  = 1'b1;
        bus_cmd_o  = BC_RDX;
        bus_addr_o = cpu_addr_i;
        if (bus_gnt_i) begin
          ready_o  = 1'b1;
          upd_o    = 1'b1;
          upd_st_o = ST_M;
        end
      end else if (cur_st_i == ST_M) begin
        // dirty victim leaves first
        bus_req_o  = 1'b1;
        bus_cmd_o  = BC_WB;
        bus_addr_o = {cur_tag_i, req_idx};
        if (bus_gnt_i) begin
          upd_o    = 1'b1;
          upd_st_o = ST_I;
        end
      end else begin
        bus_req_o  = 1'b1;
        bus_cmd_o  = cpu_we_i ? BC_RDX : BC_RD;
        bus_addr_o = cpu_addr_i;
        if (bus_gnt_i) begin
          ready_o   = 1'b1;
          upd_o     = 1'b1;
          upd_st_o  = cpu_we_i ? ST_M : ST_S;
          upd_tag_o = req_tag;
        end
      end
    end
  end
endmodule

// File: rtl/msi_line_ctrl.sv
module msi_line_ctrl
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  output logic              cpu_ready_o,
  output logic [1:0]        cpu_state_o,
  output logic              bus_req_o,
  output logic [1:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  input  logic              bus_gnt_i,
  input  logic              snp_valid_i,
  input  logic [1:0]        snp_cmd_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              flush_o
);
  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [LINES-1:0][1:0]       st_q, st_snp, st_d;
  logic [LINES-1:0][TAG_W-1:0] tag_q, tag_d;
  logic [IDX_W-1:0]            cidx;
  logic                        upd;
  logic [1:0]                  upd_st;
  logic [TAG_W-1:0]            upd_tag;

  assign cidx = cpu_addr_i[IDX_W-1:0];

  msi_snoop_unit #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_snp (
    .st_i        (st_q),
    .tag_i       (tag_q),
    .snp_valid_i (snp_valid_i),
    .snp_cmd_i   (snp_cmd_i),
    .snp_addr_i  (snp_addr_i),
    .st_o        (st_snp),
    .flush_o     (flush_o)
  );

  msi_cpu_unit #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_cpu (
    .cpu_req_i  (cpu_req_i),
    .cpu_we_i   (cpu_we_i),
    .cpu_addr_i (cpu_addr_i),
    .cur_st_i   (st_snp[cidx]),
    .cur_tag_i  (tag_q[cidx]),
    .bus_gnt_i  (bus_gnt_i),
    .bus_req_o  (bus_req_o),
    .bus_cmd_o  (bus_cmd_o),
    .bus_addr_o (bus_addr_o),
    .ready_o    (cpu_ready_o),
    .upd_o      (upd),
    .upd_st_o   (upd_st),
    .upd_tag_o  (upd_tag)
  );

  always_comb begin
    st_d  = st_snp;
    tag_d = tag_q;
    if (upd) begin
      st_d[cidx]  = upd_st;
      tag_d[cidx] = upd_tag;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= '0;
      tag_q <= '0;
    end else begin
      st_q  <= st_d;
      tag_q <= tag_d;
    end
  end

  assign cpu_state_o = (st_q[cidx] != ST_I && tag_q[cidx] == cpu_addr_i[ADDR_W-1:IDX_W])
                       ? st_q[cidx] : ST_I;
endmodule

// File: rtl/msi_line_ctrl_chk.sv
module msi_line_ctrl_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_req_i,
  input logic              cpu_we_i,
  input logic [ADDR_W-1:0] cpu_addr_i,
  input logic              cpu_ready_o,
  input logic [1:0]        cpu_state_o,
  input logic              bus_req_o,
  input logic [1:0]        bus_cmd_o,
  input logic              snp_valid_i,
  input logic [1:0]        snp_cmd_i,
  input logic              flush_o
);
  a_r5_flush_on_snoop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> snp_valid_i && (snp_cmd_i == 2'b01 || snp_cmd_i == 2'b10));

  a_r1_local_read_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && !cpu_we_i && cpu_ready_o && !bus_req_o) |-> cpu_state_o != 2'b00);

  a_r4_local_write_mod: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && cpu_we_i && cpu_ready_o && !bus_req_o) |-> cpu_state_o == 2'b10);

  a_r3_write_leaves_mod: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && cpu_we_i && cpu_ready_o) |=>
      (cpu_addr_i != $past(cpu_addr_i)) || cpu_state_o == 2'b10);

  a_r8_wb_not_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_cmd_o == 2'b11) |-> !cpu_ready_o);

  a_r9_bus_from_cpu: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> cpu_req_i && bus_cmd_o != 2'b00);

  a_r2_rd_only_reads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_cmd_o == 2'b01) |-> !cpu_we_i);
endmodule

bind msi_line_ctrl msi_line_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cpu_req_i   (cpu_req_i),
  .cpu_we_i    (cpu_we_i),
  .cpu_addr_i  (cpu_addr_i),
  .cpu_ready_o (cpu_ready_o),
  .cpu_state_o (cpu_state_o),
  .bus_req_o   (bus_req_o),
  .bus_cmd_o   (bus_cmd_o),
  .snp_valid_i (snp_valid_i),
  .snp_cmd_i   (snp_cmd_i),
  .flush_o     (flush_o)
);

// File: tb/sim_msi_line_ctrl.sv
module sim_msi_line_ctrl;
  localparam int AW = 8;
  localparam int IW = 2;
  localparam int NL = 1 << IW;
  localparam int TW = AW - IW;
  localparam logic [1:0] I = 2'b00, S = 2'b01, M = 2'b10;
  localparam logic [1:0] RD = 2'b01, RDX = 2'b10, WB = 2'b11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          cpu_req = 0, cpu_we = 0, bus_gnt = 0, snp_valid = 0;
  logic [AW-1:0] cpu_addr = '0, snp_addr = '0;
  logic [1:0]    snp_cmd = '0;
  logic          cpu_ready, bus_req, flush;
  logic [1:0]    cpu_state, bus_cmd;
  logic [AW-1:0] bus_addr;

  msi_line_ctrl #(.ADDR_W(AW), .IDX_W(IW)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr),
    .cpu_ready_o(cpu_ready), .cpu_state_o(cpu_state),
    .bus_req_o(bus_req), .bus_cmd_o(bus_cmd), .bus_addr_o(bus_addr),
    .bus_gnt_i(bus_gnt),
    .snp_valid_i(snp_valid), .snp_cmd_i(snp_cmd), .snp_addr_i(snp_addr),
    .flush_o(flush)
  );

  int errors = 0, checks = 0;
  logic [1:0]    m_st [NL];
  logic [TW-1:0] m_tag[NL];
  logic          last_rdy;

  task automatic chk(input string r, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  // one clock: drive after the edge, compare in mid-cycle, then advance the model
  task automatic step(input logic rq, input logic we, input logic [AW-1:0] a,
                      input logic g, input logic sv, input logic [1:0] sc,
                      input logic [AW-1:0] sa, input string r);
    logic [1:0]    ps[NL];
    logic [1:0]    cs, e_cmd, e_cst;
    logic [TW-1:0] ct;
    logic [AW-1:0] e_addr;
    logic          e_fl, e_req, e_rdy, hit;
    int            si, ci;
    @(posedge clk); #1;
    cpu_req = rq; cpu_we = we; cpu_addr = a;
    bus_gnt = g; snp_valid = sv; snp_cmd = sc; snp_addr = sa;
    #2;
    si = int'(sa[IW-1:0]);
    ci = int'(a[IW-1:0]);
    for (int k = 0; k < NL; k++) ps[k] = m_st[k];
    e_cst = (m_st[ci] != I && m_tag[ci] == a[AW-1:IW]) ? m_st[ci] : I;
    e_fl = 1'b0;
    if (sv && (sc == RD || sc == RDX) && m_st[si] != I && m_tag[si] == sa[AW-1:IW]) begin
      e_fl = (m_st[si] == M);
      ps[si] = (sc == RDX) ? I : S;
    end
    cs = ps[ci]; ct = m_tag[ci];
    hit = (cs != I) && (ct == a[AW-1:IW]);
    e_req = 0; e_rdy = 0; e_cmd = 0; e_addr = '0;
    if (rq) begin
      if (hit && (!we || cs == M)) e_rdy = 1;
      else if (hit) begin
        e_req = 1; e_cmd = RDX; e_addr = a;
        if (g) begin e_rdy = 1; ps[ci] = M; end
      end else if (cs == M) begin
        e_req = 1; e_cmd = WB; e_addr = {ct, a[IW-1:0]};
        if (g) ps[ci] = I;
      end else begin
        e_req = 1; e_cmd = we ? RDX : RD; e_addr = a;
        if (g) begin e_rdy = 1; ps[ci] = we ? M : S; m_tag[ci] = a[AW-1:IW]; end
      end
    end
    chk(r, "cpu_state", cpu_state, e_cst);
    chk(r, "flush", flush, e_fl);
    chk(r, "ready", cpu_ready, e_rdy);
    chk(r, "bus_req", bus_req, e_req);
    if (e_req) begin
      chk(r, "bus_cmd", bus_cmd, e_cmd);
      chk(r, "bus_addr", bus_addr, e_addr);
    end
    for (int k = 0; k < NL; k++) m_st[k] = ps[k];
    last_rdy = e_rdy;
  endtask

  localparam logic [AW-1:0] A0 = 8'h10, A1 = 8'h20, B0 = 8'h05;

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic          rq, we;
    logic [AW-1:0] a;
    for (int k = 0; k < NL; k++) begin m_st[k] = I; m_tag[k] = '0; end
    #10;
    chk("R12", "reset bus_req", bus_req, 0);
    chk("R12", "reset flush", flush, 0);
    chk("R12", "reset ready", cpu_ready, 0);
    chk("R12", "reset state", cpu_state, I);
    #8 rst_n = 1'b1;
    step(0, 0, A0, 0, 0, 0, 0, "R12");
    // read miss with stall
    step(1, 0, A0, 0, 0, 0, 0, "R9");
    step(1, 0, A0, 0, 0, 0, 0, "R9");
    step(1, 0, A0, 1, 0, 0, 0, "R2");
    step(1, 0, A0, 0, 0, 0, 0, "R1");
    // upgrade then local write
    step(1, 1, A0, 0, 0, 0, 0, "R9");
    step(1, 1, A0, 1, 0, 0, 0, "R3");
    step(1, 1, A0, 0, 0, 0, 0, "R4");
    step(1, 0, A0, 0, 0, 0, 0, "R1");
    // snoops on dirty and shared copies
    step(0, 0, A0, 0, 1, RD, A0, "R5");
    step(0, 0, A0, 0, 0, 0, 0, "R5");
    step(0, 0, A0, 0, 1, RD, A0, "R7");
    step(0, 0, A0, 0, 1, RDX, A0, "R7");
    step(0, 0, A0, 0, 0, 0, 0, "R7");
    step(1, 1, A0, 1, 0, 0, 0, "R3");
    step(0, 0, A0, 0, 1, RDX, A0, "R6");
    step(0, 0, A0, 0, 0, 0, 0, "R6");
    // dirty victim writeback
    step(1, 1, A0, 1, 0, 0, 0, "R3");
    step(1, 0, A1, 0, 0, 0, 0, "R8");
    step(1, 0, A1, 1, 0, 0, 0, "R8");
    step(1, 0, A1, 1, 0, 0, 0, "R8");
    step(0, 0, A0, 0, 0, 0, 0, "R8");
    // same-cycle snoop applied first
    step(1, 0, A1, 0, 1, RDX, A1, "R10");
    step(1, 0, A1, 1, 0, 0, 0, "R10");
    // ignored snoops
    step(1, 1, A1, 1, 0, 0, 0, "R3");
    step(0, 0, A1, 0, 1, RDX, A0, "R11");
    step(0, 0, A1, 0, 1, WB, A1, "R11");
    step(0, 0, B0, 0, 1, RDX, B0, "R11");
    step(0, 0, A1, 0, 0, 0, 0, "R11");
    // random mix
    void'($urandom(32'd1234));
    rq = 0; we = 0; a = '0; last_rdy = 1;
    for (int n = 0; n < 3000; n++) begin
      logic          g, sv;
      logic [1:0]    sc;
      logic [AW-1:0] sa;
      if (!rq || last_rdy) begin
        rq = ($urandom % 10) < 7;
        we = $urandom % 2;
        a  = {TW'(1 + $urandom % 2), IW'($urandom % NL)};
      end
      g  = ($urandom % 10) < 6;
      sv = ($urandom % 10) < 3;
      sc = 2'($urandom % 4);
      sa = {TW'(1 + $urandom % 2), IW'($urandom % NL)};
      step(rq, we, a, g, sv, sc, sa, "R10");
      if (!rq) last_rdy = 1;
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule